// File: doc/BRIEF.md
# Tapered Bitstream Window with Overlapped Oversampling

This block turns the one-bit output of a delta-sigma modulator into multi-bit samples. Each clock it shifts one modulator bit into a 30-bit history. A fixed, symmetric taper gives every history position a weight. The weighted count of ones, halved, is the byte-wide window value.

A sequencer reads the window 1, 2 or 4 times after a start strobe. The reads are exactly 15 clocks apart. At that spacing the falling edge of one window lands on the rising edge of the next, so each bit that two reads share carries a combined weight equal to the peak weight. The overlapped reads therefore act as one longer window with a flat top. The sequencer adds the byte values and divides the total by the read count with a right shift. It reports the result with a one-clock valid pulse.

Top module: `taper_oversampler`

## Requirements
- R1: On each rising clock edge out of reset, `bit_in` enters history position 0 and every older bit moves up one position. Position 29 holds the oldest of the 30 stored bits.
- R2: History positions 0 and 29 have weight 0. Positions 1 to 13 have the weights 1, 4, 7, 10, 13, 16, 17, 18, 21, 24, 27, 30, 33. Positions 14 and 15 have weight 34. Position p from 16 to 28 has the weight of position 29 - p.
- R3: The window byte is the sum of the weights of the positions holding a one, divided by 2 and truncated. With all 30 history bits set it is 255.
- R4: The first read is taken at the clock edge that accepts the start strobe, using the history as it stood before that edge. Each further read is taken exactly 15 clock edges after the previous one.
- R5: For p from 1 to 13, weight(p) + weight(p + 15) = 34. A bit covered by two consecutive reads therefore contributes the peak weight in total.
- R6: The read count N is taken from `osr_log2` at the accepting edge. Code 0 selects 1 read, code 1 selects 2 reads, code 2 selects 4 reads, and code 3 is treated as code 2.
- R7: `result` is the sum of the N window bytes shifted right by log2(N). The sum is held in a 10-bit accumulator, so 4 reads of 255 give 255 with no wrap.
- R8: `result_valid` is high for exactly one clock, the cycle after the edge of the final read. It is low at every other time. `result` holds its value until the next sequence completes.
- R9: A start strobe that arrives while a sequence is running is ignored. It changes neither the read count, the read times nor the result.
- R10: While `rst_n` is low, `result_valid` and `result` are 0, the history is cleared and no sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the modulator delivers one bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Modulator output bit |
| start | input | 1 | Begins an oversampling sequence when idle |
| osr_log2 | input | 2 | Log2 of the read count; 3 is treated as 2 |
| result | output | 8 | Averaged window value |
| result_valid | output | 1 | One-clock pulse marking a new `result` |

## Verification
The hardest case to reach from the ports is a single bit that two reads of one sequence both cover. Only there does the complementary weight property show in the result. The bench places one isolated one at every offset across the history and the first read interval of a two-read sequence, so the bit crosses each tap of both windows. It also sends extra start strobes in the middle of four-read sequences, with a different read count, to confirm that they are ignored. Sweeps of all read-count codes against all-zero, all-one, alternating, sparse and pseudo-random streams cover the scaling and the no-wrap limit.

// File: rtl/taper_pkg.sv
package taper_pkg;
   localparam int HIST_LEN  = 30;
   localparam int SPACING   = 15;
   localparam int PEAK_W    = 34;
   localparam int RISE_LEN  = 13;

   // weight of history position pos; symmetric, zero at both ends
   function automatic int tap_weight(input int pos);
      int k;
      if (pos <= 0 || pos >= HIST_LEN - 1) return 0;
      k = pos - 1;
      if (k > HIST_LEN - 3 - RISE_LEN - 1) k = HIST_LEN - 3 - k;
      if (k >= RISE_LEN) return PEAK_W;
      if (k <= 5) return 1 + 3 * k;
      if (k == 6) return PEAK_W / 2;
      return PEAK_W - tap_weight(RISE_LEN - k);
   endfunction
endpackage

// File: rtl/taper_history.sv
module taper_history #(
   parameter int LEN = 30
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           bit_in,
   output logic [LEN-1:0] hist
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= '0;
      else        hist <= {hist[LEN-2:0], bit_in};
   end
endmodule

// File: rtl/taper_window.sv
module taper_window
   import taper_pkg::*;
#(
   parameter int LEN   = 30,
   parameter int RES_W = 8
) (
   input  logic [LEN-1:0]   hist,
   output logic [RES_W-1:0] win_byte
);
   localparam int SUM_W = RES_W + 1;

   logic [SUM_W-1:0] term [LEN];
   logic [SUM_W-1:0] total;

   for (genvar i = 0; i < LEN; i++) begin : g_tap
      localparam logic [SUM_W-1:0] WT = SUM_W'(tap_weight(i));
      assign term[i] = hist[i] ? WT : '0;
   end

   always_comb begin
      total = '0;
      for (int i = 0; i < LEN; i++) total = total + term[i];
   end

   assign win_byte = total[SUM_W-1:1];
endmodule

// File: rtl/taper_seq.sv
module taper_seq #(
   parameter int RES_W    = 8,
   parameter int MAX_LOG2 = 2,
   parameter int LOG2_W   = 2,
   parameter int SPACING  = 15,
   parameter int GAP_W    = 4,
   parameter int CNT_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [LOG2_W-1:0] osr_log2,
   input  logic [RES_W-1:0]  win_byte,
   output logic [RES_W-1:0]  result,
   output logic              result_valid,
   output logic              busy,
   output logic [GAP_W-1:0]  gap,
   output logic [CNT_W-1:0]  reads_left
);
   localparam int ACC_W = RES_W + MAX_LOG2;

   logic [ACC_W-1:0]  acc, sum_next;
   logic [LOG2_W-1:0] l_q, l_req, l_use;
   logic [CNT_W-1:0]  rem_next;
   logic              accept, fire, take;
   logic [ACC_W-1:0]  div_opt [MAX_LOG2+1];
   logic [ACC_W-1:0]  quotient;

   assign l_req    = (osr_log2 > LOG2_W'(MAX_LOG2)) ? LOG2_W'(MAX_LOG2) : osr_log2;
   assign accept   = start && !busy;
   assign fire     = busy && (gap == '0);
   assign take     = accept || fire;
   assign sum_next = (accept ? '0 : acc) + ACC_W'(win_byte);
   assign rem_next = accept ? CNT_W'((1 << l_req) - 1) : reads_left - 1'b1;
   assign l_use    = accept ? l_req : l_q;

   for (genvar s = 0; s <= MAX_LOG2; s++) begin : g_div
      assign div_opt[s] = sum_next >> s;
   end

   always_comb begin
      quotient = div_opt[0];
      for (int s = 1; s <= MAX_LOG2; s++)
         if (int'(l_use) == s) quotient = div_opt[s];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc          <= '0;
         l_q          <= '0;
         busy         <= 1'b0;
         gap          <= '0;
         reads_left   <= '0;
         result       <= '0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= 1'b0;
         if (take) begin
            if (rem_next == '0) begin
               result       <= quotient[RES_W-1:0];
               result_valid <= 1'b1;
               busy         <= 1'b0;
               acc          <= '0;
               reads_left   <= '0;
            end else begin
               acc        <= sum_next;
               busy       <= 1'b1;
               gap        <= GAP_W'(SPACING - 1);
               reads_left <= rem_next;
            end
            if (accept) l_q <= l_req;
         end else if (busy) begin
            gap <= gap - 1'b1;
         end
      end
   end
endmodule

// File: rtl/taper_oversampler.sv
module taper_oversampler
   import taper_pkg::*;
#(
   parameter int RES_W    = 8,
   parameter int MAX_LOG2 = 2,
   parameter int LOG2_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_in,
   input  logic              start,
   input  logic [LOG2_W-1:0] osr_log2,
   output logic [RES_W-1:0]  result,
   output logic              result_valid
);
   localparam int GAP_W = $clog2(SPACING);
   localparam int CNT_W = MAX_LOG2 + 1;

   if (HIST_LEN != 2 * SPACING) begin : g_bad_spacing
      $error("history length must be twice the read spacing");
   end
   if (RES_W != 8) begin : g_bad_res
      $error("window weights are sized for an 8-bit result");
   end
   if ((1 << LOG2_W) <= MAX_LOG2) begin : g_bad_log2
      $error("osr_log2 too narrow for MAX_LOG2");
   end

   logic [HIST_LEN-1:0] hist;
   logic [RES_W-1:0]    win_byte;
   logic                busy;
   logic [GAP_W-1:0]    gap_cnt;
   logic [CNT_W-1:0]    reads_left;

   taper_history #(.LEN(HIST_LEN)) u_hist (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .hist(hist)
   );

   taper_window #(.LEN(HIST_LEN), .RES_W(RES_W)) u_win (
      .hist(hist), .win_byte(win_byte)
   );

   taper_seq #(
      .RES_W(RES_W), .MAX_LOG2(MAX_LOG2), .LOG2_W(LOG2_W),
      .SPACING(SPACING), .GAP_W(GAP_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .osr_log2(osr_log2),
      .win_byte(win_byte), .result(result), .result_valid(result_valid),
      .busy(busy), .gap(gap_cnt), .reads_left(reads_left)
   );
endmodule

// File: rtl/taper_oversampler_chk.sv
module taper_oversampler_chk #(
   parameter int GAP_W = 4,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             result_valid,
   input logic             busy,
   input logic [GAP_W-1:0] gap,
   input logic [CNT_W-1:0] reads_left
);
   // R8: valid never lasts two cycles
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |=> !result_valid);

   // R8: valid only appears once the sequence has closed
   a_r8_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      result_valid |-> !busy);

   // R4: reads are separated by a steady countdown
   a_r4_gap_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && gap != '0) |=> (busy && gap == $past(gap) - 1'b1));

   // R9: a start during a sequence leaves the remaining read count untouched
   a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && gap != '0) |=> (reads_left == $past(reads_left)));

   // R6: no more than three reads remain after the first
   a_r6_read_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (reads_left != '0 && reads_left <= CNT_W'(3)));

   // R10: leaving reset finds the block quiet
   a_r10_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!result_valid && !busy));
endmodule

bind taper_oversampler taper_oversampler_chk #(.GAP_W(GAP_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .result_valid(result_valid),
   .busy(busy), .gap(gap_cnt), .reads_left(reads_left)
);

// File: tb/taper_oversampler_test.sv
`timescale 1ns/1ps
module taper_oversampler_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_in = 1'b0;
   logic       start = 1'b0;
   logic [1:0] osr_log2 = 2'd0;
   logic [7:0] result;
   logic       result_valid;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   logic model [30];
   logic [15:0] lfsr = 16'hACE1;
   localparam int RISE [13] = '{1, 4, 7, 10, 13, 16, 17, 18, 21, 24, 27, 30, 33};

   always #10 clk = ~clk;

   taper_oversampler uut (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .start(start),
      .osr_log2(osr_log2), .result(result), .result_valid(result_valid)
   );

   // R2 weights written from the requirement table
   function automatic int wt(input int pos);
      int k;
      if (pos == 0 || pos == 29) return 0;
      if (pos == 14 || pos == 15) return 34;
      k = (pos <= 13) ? pos : 29 - pos;
      return RISE[k-1];
   endfunction

   function automatic int win_model();
      int s = 0;
      for (int i = 0; i < 30; i++) if (model[i]) s += wt(i);
      return s / 2;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic gen_bit(input int pat, input int c, input int imp);
      case (pat)
         0: return 1'b0;
         1: return 1'b1;
         2: return c[0];
         3: return (c % 5) == 0;
         4: return lfsr[0];
         default: return c == imp;
      endcase
   endfunction

   // drive at a falling edge, take one rising edge, update model (R1)
   task automatic step(input logic b, input logic st, input logic [1:0] l);
      bit_in = b; start = st; osr_log2 = l;
      @(posedge clk);
      #1;
      for (int i = 29; i > 0; i--) model[i] = model[i-1];
      model[0] = b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
   endtask

   task automatic run_seq(input int l, input int pat, input int imp, input bit extra, input string req);
      int n, ls, sum, c, last;
      bit early;
      ls = (l > 2) ? 2 : l;
      n = 1 << ls;
      sum = 0; c = 0; early = 0;
      for (int p = 0; p < 30; p++) begin
         step(gen_bit(pat, c, imp), 1'b0, 2'd0);
         c++;
      end
      last = 15 * (n - 1);
      for (int s = 0; s <= last; s++) begin
         if (s > 0 && result_valid) early = 1;
         if (s % 15 == 0) sum += win_model();
         if (s == 0) step(gen_bit(pat, c, imp), 1'b1, 2'(l));
         else step(gen_bit(pat, c, imp), extra && (s == 7 || s == 20), 2'd0);
         c++;
      end
      check(!early, {req, " R8 no early valid"}, int'(early), 0);
      check(result_valid === 1'b1, {req, " R8 valid after last read"}, int'(result_valid), 1);
      check(result === 8'(sum >> ls), {req, " R7 result"}, int'(result), sum >> ls);
      step(1'b0, 1'b0, 2'd0);
      check(result_valid === 1'b0, {req, " R8 pulse width"}, int'(result_valid), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         compared++; mismatched++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 30; i++) model[i] = 1'b0;
      repeat (3) @(negedge clk);
      // R10: reset state
      check(result_valid === 1'b0, "R10 valid in reset", int'(result_valid), 0);
      check(result === 8'd0, "R10 result in reset", int'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R6 R7: every read-count code against several streams
      for (int l = 0; l < 4; l++)
         for (int pat = 0; pat < 5; pat++)
            run_seq(l, pat, -1, 1'b0, $sformatf("R6 code=%0d pat=%0d", l, pat));

      // R3: all ones gives the full byte
      run_seq(0, 1, -1, 1'b0, "R3 full scale");
      check(result === 8'd255, "R3 full-scale byte", int'(result), 255);

      // R2 R5: isolated one at every offset across two overlapping reads
      for (int k = 0; k < 45; k++)
         run_seq(1, 5, k, 1'b0, $sformatf("R5 impulse=%0d", k));

      // R4: impulse sweep with a single read checks the first-read timing
      for (int k = 20; k < 32; k++)
         run_seq(0, 5, k, 1'b0, $sformatf("R4 impulse=%0d", k));

      // R9: start strobes during a four-read sequence are ignored
      run_seq(2, 4, -1, 1'b1, "R9 extra start");
      run_seq(3, 3, -1, 1'b1, "R9 extra start sparse");

      // R1: history fully flushes after 30 zero bits
      run_seq(0, 0, -1, 1'b0, "R1 flushed");
      check(result === 8'd0, "R1 zero history", int'(result), 0);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule